// File: doc/BRIEF.md
# Programmable Periodic Timer with Time Latch

This block is a memory-mapped time source. A sub-microsecond prescaler, a microseconds counter and a seconds counter run continuously from the system clock. A separate period counter raises a periodic event whose rate software programs in hertz. Every event adds one to a small pending counter, and the interrupt output stays high while that counter is above zero.

Software takes a coherent snapshot of the time by touching the latch address. It then reads the captured seconds and microseconds at leisure, because the live counters keep running. The interrupt rate is written and read back at one address. Any access to the acknowledge address retires exactly one pending event, so a handler that falls behind sees every missed period. The clock rate is the product of the parameters `TICKS_PER_US` and `US_PER_S`. The event period is that clock rate divided by the programmed rate.

Top module: `periodic_timer_latch`

## Requirements
- R1: After reset `irq` is low, and reads of the seconds (0x010), microseconds (0x020) and rate (0x100) addresses return 0. Reads of any other address return 0 at all times.
- R2: The microseconds count advances by one every `TICKS_PER_US` clocks. When it steps past `US_PER_S`-1 it returns to 0 and the seconds count advances by one. After n clocks out of reset the live time is sec = (n / TICKS_PER_US) / US_PER_S and usec = (n / TICKS_PER_US) mod US_PER_S.
- R3: A read or a write at address 0x000 copies the live seconds and microseconds into the snapshot registers, using their values at that clock edge.
- R4: A read at 0x010 returns the snapshot seconds and a read at 0x020 returns the snapshot microseconds. Both hold their values until the next access at 0x000.
- R5: A write at 0x100 stores the rate in hertz, and a read at 0x100 returns it.
- R6: A write of a nonzero rate f sets the period P = max(1, CLK_HZ / f) clocks, where CLK_HZ = TICKS_PER_US * US_PER_S, and restarts the period count. Events occur P, 2P, 3P, ... clocks after the write edge. An enabled period of M clocks therefore yields floor(M / P) events.
- R7: A write of rate 0 stops new events. Events already pending stay pending.
- R8: A read or a write at 0x110 removes exactly one pending event. It has no effect when nothing is pending. If an event and an acknowledge fall in the same cycle, the count does not change.
- R9: The pending count saturates at 255 and never wraps.
- R10: `irq` is high exactly while the pending count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One access in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the access |
| irq | output | 1 | High while events are pending |

## Verification
The snapshot path is sampled at dozens of points spaced irregularly. The spacing puts samples on both phases of the prescaler, on every microseconds value and across several seconds carries, so an error in the wrap value or the carry shows up at once. Rates are swept from 0 to above the clock rate, with each event count recovered by counting acknowledges. This separates an off-by-one period, a missing clamp and a timer that does not stop. Dedicated patterns cover the remaining cases: rewriting the rate just before the period ends (restart versus free-running), running for exactly P and P-1 clocks, overrunning 255 events, and acknowledging while nothing is pending.

// File: rtl/periodic_timer_latch.sv
module periodic_timer_latch #(
  parameter int unsigned TICKS_PER_US = 50,
  parameter int unsigned US_PER_S     = 1000000,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PEND_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned CLK_HZ = TICKS_PER_US * US_PER_S;
  localparam int SUB_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam int US_W  = (US_PER_S > 1) ? $clog2(US_PER_S) : 1;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [ADDR_W-1:0] A_SNAP = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_USEC = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] A_RATE = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'('h110);

  logic [SUB_W-1:0]  sub_q;
  logic [US_W-1:0]   us_q, snap_us;
  logic [DATA_W-1:0] sec_q, snap_sec;
  logic [DATA_W-1:0] rate_q, per_q, pcnt_q, quot;
  logic [PEND_W-1:0] pend_q;

  wire tick    = (sub_q == SUB_W'(TICKS_PER_US - 1));
  wire us_last = (us_q == US_W'(US_PER_S - 1));
  wire snap_hit = bus_valid && (bus_addr == A_SNAP);
  wire rate_wr  = bus_valid && bus_write && (bus_addr == A_RATE);
  wire ack_hit  = bus_valid && (bus_addr == A_ACK);
  wire fire     = (rate_q != '0) && (pcnt_q == per_q - 1'b1);

  assign quot = (bus_wdata == '0) ? '1 : DATA_W'(CLK_HZ) / bus_wdata;
  assign irq  = (pend_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q <= '0;
      us_q  <= '0;
      sec_q <= '0;
    end else if (tick) begin
      sub_q <= '0;
      if (us_last) begin
        us_q  <= '0;
        sec_q <= sec_q + 1'b1;
      end else begin
        us_q <= us_q + 1'b1;
      end
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_sec <= '0;
      snap_us  <= '0;
    end else if (snap_hit) begin
      snap_sec <= sec_q;
      snap_us  <= us_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      per_q  <= DATA_W'(1);
      pcnt_q <= '0;
    end else if (rate_wr) begin
      rate_q <= bus_wdata;
      pcnt_q <= '0;
      if (bus_wdata != '0) per_q <= (quot == '0) ? DATA_W'(1) : quot;
    end else if (rate_q != '0) begin
      pcnt_q <= fire ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else if (fire && !ack_hit && pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
    else if (ack_hit && !fire && pend_q != '0) pend_q <= pend_q - 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_SEC:   bus_rdata = snap_sec;
        A_USEC:  bus_rdata = DATA_W'(snap_us);
        A_RATE:  bus_rdata = rate_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2
  us_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && us_last) |=> (us_q == '0 && sec_q == $past(sec_q) + 1'b1));

  // R3
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_hit |=> (snap_us == $past(us_q) && snap_sec == $past(sec_q)));

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0 && !rate_wr && !ack_hit) |=> $stable(pend_q));

  // R8
  ack_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !fire && pend_q != '0) |=> (pend_q == $past(pend_q) - 1'b1));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == PEND_MAX && !ack_hit) |=> (pend_q == PEND_MAX));

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !fire && pend_q == PEND_W'(1)) |=> !irq);
endmodule

// File: tb/tb_periodic_timer_latch.sv
module tb_periodic_timer_latch;
  localparam int T = 2;
  localparam int US = 10;
  localparam int HZ = T * US;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;

  int total = 0, bad = 0, cyc = 0;
  int last_n;
  logic [31:0] rd;

  periodic_timer_latch #(.TICKS_PER_US(T), .US_PER_S(US)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int addr, input int data);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = 12'(addr); bus_wdata = data;
    last_n = cyc;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 0; bus_write = 0;
  endtask

  task automatic count_acks(output int c);
    c = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      #1 if (!irq) break;
      access(k[0], 'h110, 0);
      c++;
    end
  endtask

  task automatic run_rate(input int f, input int m, input string req);
    int p, exp, got;
    access(1, 'h100, f);
    access(0, 'h100, 0);
    chk(rd == f, "R5", rd, f);
    repeat (m - 2) @(posedge clk);
    access(1, 'h100, 0);
    repeat (10) @(posedge clk);
    p = (f == 0) ? 1 : ((HZ / f) < 1 ? 1 : HZ / f);
    exp = (f == 0) ? 0 : m / p;
    if (exp > 255) exp = 255;
    count_acks(got);
    chk(got == exp, req, got, exp);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int got, es, eu, tu;
    logic [31:0] s0, u0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 chk(irq == 0, "R1 irq", irq, 0);
    access(0, 'h010, 0); chk(rd == 0, "R1 sec", rd, 0);
    access(0, 'h020, 0); chk(rd == 0, "R1 usec", rd, 0);
    access(0, 'h100, 0); chk(rd == 0, "R1 rate", rd, 0);
    access(0, 'h0F0, 0); chk(rd == 0, "R1 unmapped", rd, 0);

    // R2 R3 R4 snapshot sweep
    for (int i = 0; i < 40; i++) begin
      repeat (i % 5) @(posedge clk);
      access(i % 2, 'h000, 0);
      tu = last_n / T; es = tu / US; eu = tu % US;
      access(0, 'h010, 0); s0 = rd;
      chk(s0 == es, "R2 R3 seconds", s0, es);
      access(0, 'h020, 0); u0 = rd;
      chk(u0 == eu, "R2 R3 microseconds", u0, eu);
    end
    repeat (13) @(posedge clk);
    access(0, 'h010, 0); chk(rd == s0, "R4 sec held", rd, s0);
    access(0, 'h020, 0); chk(rd == u0, "R4 usec held", rd, u0);

    // R6 R7 rate sweep
    begin
      int rates [11] = '{0, 1, 2, 3, 4, 5, 6, 7, 10, 20, 25};
      foreach (rates[j]) run_rate(rates[j], 21, "R6 R7 R8 rate sweep");
    end
    run_rate(4, 5, "R6 exact period");
    run_rate(4, 4, "R6 one short of period");

    // R6 restart on rewrite
    access(1, 'h100, 4);
    repeat (2) @(posedge clk);
    access(1, 'h100, 4);
    repeat (3) @(posedge clk);
    access(1, 'h100, 0);
    repeat (5) @(posedge clk);
    count_acks(got);
    chk(got == 0, "R6 restart", got, 0);

    // R8 ack with nothing pending
    access(1, 'h110, 0);
    access(0, 'h110, 0);
    #1 chk(irq == 0, "R8 R10 empty ack", irq, 0);
    run_rate(4, 5, "R8 no underflow");

    // R9 saturation
    run_rate(25, 300, "R9 saturate");
    #1 chk(irq == 0, "R10 irq low after drain", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule